// File: doc/BRIEF.md
# DMA Stream Width Adapter

This block is the data path of one DMA stream. It moves data between a peripheral-side port and a memory-side port, and the data width of each port is set to 8, 16 or 32 bits on its own. When the source is narrower than the destination, the block packs consecutive source items into one wider word. When the source is wider, it splits each word into narrower items. Bytes always keep little-endian order: the first byte of the stream lands in the lowest lane.

The block also generates the addresses on both ports. Each port has a valid/ready request with its own address, write flag and data. The item count is given in peripheral-side items. The stream ends when the destination accepts its last write, and a one-cycle done pulse marks that point.

The direction bit chooses which port reads and which writes. For a memory-to-memory copy, the peripheral port is connected to the source memory. A configuration that would leave the last memory-side word only partly filled is refused when the stream is started.

Top module: `dma_width_adapter`

## Requirements
- R1: Packing: when the source item is narrower than the destination item, each destination write carries the next stream bytes in little-endian order (first byte at bits [7:0], then [15:8], [23:16], [31:24]). Write data bits above the destination width are zero.
- R2: Unpacking: when the source item is wider, its bytes leave as successive destination items starting from the lowest lane.
- R3: With the fixed-stride control low and peripheral increment on, the peripheral address advances by the peripheral size in bytes (1, 2 or 4) after each peripheral handshake.
- R4: With the fixed-stride control high and peripheral increment on, the peripheral address advances by 4 after each peripheral handshake, whatever the peripheral width.
- R5: With memory increment on, the memory address advances by the memory size in bytes after each memory handshake.
- R6: When a side's increment is off, that side's address stays at its base value for the whole stream.
- R7: `remaining` loads the programmed count at start and drops by one on each peripheral handshake. Exactly `count` peripheral transfers and count×psize/msize memory transfers take place.
- R8: A destination write is requested only when the holding register has at least as many valid bytes as the destination width.
- R9: `done` is high for exactly one cycle, in the cycle after the last destination handshake. At that point `remaining` is zero and `busy` is low.
- R10: At start, `config_error` is set and no request is raised if any of these hold: count×psize is not a multiple of msize, count is zero, or either size code is 3. Size codes are 0=8, 1=16 and 2=32 bits. A later legal start clears `config_error`.
- R11: A transfer happens only in a cycle where valid and ready are both high. While valid waits for ready, the address stays stable.
- R12: With `dir`=0 the peripheral port reads (write flag 0) and the memory port writes. With `dir`=1 it is the other way round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a stream with the present configuration; ignored while busy |
| dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| psize | input | 2 | Peripheral item size code (0=8, 1=16, 2=32 bits) |
| msize | input | 2 | Memory item size code |
| p_inc | input | 1 | Peripheral address increment enable |
| m_inc | input | 1 | Memory address increment enable |
| p_fixed4 | input | 1 | Peripheral stride fixed at 4 bytes |
| count | input | CW | Number of peripheral-side items |
| p_base | input | AW | Peripheral start address |
| m_base | input | AW | Memory start address |
| p_valid | output | 1 | Peripheral port request |
| p_ready | input | 1 | Peripheral port grant |
| p_write | output | 1 | Peripheral request is a write |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data, valid in the handshake cycle |
| m_valid | output | 1 | Memory port request |
| m_ready | input | 1 | Memory port grant |
| m_write | output | 1 | Memory request is a write |
| m_addr | output | AW | Memory address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data, valid in the handshake cycle |
| busy | output | 1 | Stream in progress |
| done | output | 1 | One-cycle completion pulse |
| config_error | output | 1 | Last start was refused |
| remaining | output | CW | Peripheral items not yet transferred |

## Verification
A source read and a destination write can fall in the same cycle. The read then appends bytes behind the lanes that the write is shifting out. Equal-width streams, and packing with waits on the destination side, produce this overlap. The bench grants both ports at random, which makes the overlap happen often. It judges the result by comparing every destination address and data word against a byte stream rebuilt from the source addresses. A lane lost or duplicated during an overlap shows up as a data mismatch or as a wrong transfer count at the done pulse.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

    typedef struct packed {
        logic       dir;
        logic [1:0] psz;
        logic [1:0] msz;
        logic       pinc;
        logic       minc;
        logic       pfix;
    } dwa_cfg_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            2'd2:    size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] lane_keep(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    lane_keep = 32'h0000_00FF;
            3'd2:    lane_keep = 32'h0000_FFFF;
            default: lane_keep = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dwa_cfg_check.sv
module dwa_cfg_check #(
    parameter int CW = 16
) (
    input  logic [1:0]  psz,
    input  logic [1:0]  msz,
    input  logic [CW-1:0] items,
    output logic [CW+2:0] total_bytes,
    output logic          bad
);
    import dwa_pkg::*;

    logic [2:0] mb;

    always_comb begin
        mb          = size_bytes(msz);
        total_bytes = {3'b000, items} << psz;
        bad         = (psz == 2'd3) || (msz == 2'd3) || (items == '0) ||
                      ((total_bytes & (CW+3)'(mb - 3'd1)) != '0);
    end

endmodule

// File: rtl/dwa_addr_step.sv
module dwa_addr_step #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          inc_on,
    input  logic [2:0]    stride,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)
            addr_d = base;
        else if (adv && inc_on)
            addr_d = addr_q + AW'(stride);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/dwa_pack_buf.sv
module dwa_pack_buf #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               src_fire,
    input  logic [2:0]         src_bytes,
    input  logic [8*LANES-1:0] src_data,
    input  logic               dst_fire,
    input  logic [2:0]         dst_bytes,
    output logic [8*LANES-1:0] data,
    output logic [LANES-1:0]   mask,
    output logic [2:0]         fill
);
    typedef struct packed {
        logic [8*LANES-1:0] data;
        logic [LANES-1:0]   mask;
    } buf_t;

    buf_t buf_d, buf_q;
    int   base;

    function automatic int popc(input logic [LANES-1:0] m);
        int n = 0;
        for (int i = 0; i < LANES; i++) n += int'(m[i]);
        return n;
    endfunction

    always_comb begin
        buf_d = buf_q;
        base  = 0;
        if (clear) begin
            buf_d = '0;
        end else begin
            if (dst_fire) begin
                buf_d.data = buf_q.data >> {dst_bytes, 3'b000};
                buf_d.mask = buf_q.mask >> dst_bytes;
            end
            base = popc(buf_d.mask);
            if (src_fire) begin
                for (int i = 0; i < LANES; i++) begin
                    if ((i < int'(src_bytes)) && (base + i < LANES)) begin
                        buf_d.data[8*(base+i) +: 8] = src_data[8*i +: 8];
                        buf_d.mask[base+i]          = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign data = buf_q.data;
    assign mask = buf_q.mask;
    assign fill = 3'(popc(buf_q.mask));

endmodule

// File: rtl/dma_width_adapter.sv
module dma_width_adapter #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir,
    input  logic [1:0]    psize,
    input  logic [1:0]    msize,
    input  logic          p_inc,
    input  logic          m_inc,
    input  logic          p_fixed4,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] p_base,
    input  logic [AW-1:0] m_base,
    output logic          p_valid,
    input  logic          p_ready,
    output logic          p_write,
    output logic [AW-1:0] p_addr,
    output logic [31:0]   p_wdata,
    input  logic [31:0]   p_rdata,
    output logic          m_valid,
    input  logic          m_ready,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [31:0]   m_wdata,
    input  logic [31:0]   m_rdata,
    output logic          busy,
    output logic          done,
    output logic          config_error,
    output logic [CW-1:0] remaining
);
    import dwa_pkg::*;

    localparam int LANES = 4;
    localparam int BW    = CW + 3;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        dwa_cfg_t      cfg;
        logic [CW-1:0] rem;
        logic [BW-1:0] src_left;
        logic [BW-1:0] dst_left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BW-1:0]     total_bytes;
    logic              cfg_bad;
    logic              load;
    logic [2:0]        p_bytes, m_bytes, src_bytes, dst_bytes;
    logic              src_valid, dst_valid, src_fire, dst_fire;
    logic              p_fire, m_fire;
    logic [3:0]        room_need;
    logic [2:0]        buf_fill;
    logic [LANES-1:0]  buf_mask;
    logic [31:0]       buf_data, src_word, wr_word;
    logic [2:0]        p_stride;
    logic              p_inc_q;

    dwa_cfg_check #(.CW(CW)) u_cfg (
        .psz         (psize),
        .msz         (msize),
        .items       (count),
        .total_bytes (total_bytes),
        .bad         (cfg_bad)
    );

    assign load    = start && !ctl_q.busy && !cfg_bad;
    assign p_inc_q = ctl_q.cfg.pinc;

    always_comb begin
        p_bytes   = size_bytes(ctl_q.cfg.psz);
        m_bytes   = size_bytes(ctl_q.cfg.msz);
        src_bytes = ctl_q.cfg.dir ? m_bytes : p_bytes;
        dst_bytes = ctl_q.cfg.dir ? p_bytes : m_bytes;
        room_need = {1'b0, buf_fill} + {1'b0, src_bytes};
        src_valid = ctl_q.busy && (ctl_q.src_left != '0) && (room_need <= 4'd4);
        dst_valid = ctl_q.busy && (buf_fill >= dst_bytes) && (dst_bytes != 3'd0);
        p_valid   = ctl_q.cfg.dir ? dst_valid : src_valid;
        m_valid   = ctl_q.cfg.dir ? src_valid : dst_valid;
        p_write   = ctl_q.cfg.dir;
        m_write   = !ctl_q.cfg.dir;
        p_fire    = p_valid && p_ready;
        m_fire    = m_valid && m_ready;
        src_fire  = ctl_q.cfg.dir ? m_fire : p_fire;
        dst_fire  = ctl_q.cfg.dir ? p_fire : m_fire;
        src_word  = ctl_q.cfg.dir ? m_rdata : p_rdata;
        wr_word   = buf_data & lane_keep(dst_bytes);
        p_stride  = ctl_q.cfg.pfix ? 3'd4 : p_bytes;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.busy) begin
            if (start) begin
                ctl_d.err = cfg_bad;
                if (!cfg_bad) begin
                    ctl_d.busy     = 1'b1;
                    ctl_d.cfg      = '{dir: dir, psz: psize, msz: msize, pinc: p_inc,
                                       minc: m_inc, pfix: p_fixed4};
                    ctl_d.rem      = count;
                    ctl_d.src_left = total_bytes;
                    ctl_d.dst_left = total_bytes;
                end
            end
        end else begin
            if (p_fire)
                ctl_d.rem = ctl_q.rem - 1'b1;
            if (src_fire)
                ctl_d.src_left = ctl_q.src_left - BW'(src_bytes);
            if (dst_fire) begin
                ctl_d.dst_left = ctl_q.dst_left - BW'(dst_bytes);
                if (ctl_q.dst_left == BW'(dst_bytes)) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    dwa_pack_buf #(.LANES(LANES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load),
        .src_fire  (src_fire),
        .src_bytes (src_bytes),
        .src_data  (src_word),
        .dst_fire  (dst_fire),
        .dst_bytes (dst_bytes),
        .data      (buf_data),
        .mask      (buf_mask),
        .fill      (buf_fill)
    );

    dwa_addr_step #(.AW(AW)) u_paddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .base   (p_base),
        .adv    (p_fire),
        .inc_on (ctl_q.cfg.pinc),
        .stride (p_stride),
        .addr   (p_addr)
    );

    dwa_addr_step #(.AW(AW)) u_maddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .base   (m_base),
        .adv    (m_fire),
        .inc_on (ctl_q.cfg.minc),
        .stride (m_bytes),
        .addr   (m_addr)
    );

    assign p_wdata      = wr_word;
    assign m_wdata      = wr_word;
    assign busy         = ctl_q.busy;
    assign done         = ctl_q.done;
    assign config_error = ctl_q.err;
    assign remaining    = ctl_q.rem;

endmodule

// File: rtl/dwa_checker.sv
module dwa_checker #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          p_valid,
    input logic          p_ready,
    input logic [AW-1:0] p_addr,
    input logic          m_valid,
    input logic          m_ready,
    input logic [AW-1:0] m_addr,
    input logic          busy,
    input logic          done,
    input logic          config_error,
    input logic [CW-1:0] remaining,
    input logic [3:0]    buf_mask,
    input logic [2:0]    dst_bytes,
    input logic          dst_valid,
    input logic          p_inc_q
);
    a_r11_p_hold: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid && !p_ready |=> p_valid && $stable(p_addr));

    a_r11_m_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_addr));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_state: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remaining == '0) && !busy);

    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !p_valid && !m_valid && !busy);

    a_r8_lanes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> ($countones(buf_mask) >= int'(dst_bytes)));

    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        busy && p_valid && p_ready |=> remaining == $past(remaining) - 1'b1);

    a_r6_p_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !p_inc_q && p_valid && p_ready |=> $stable(p_addr));

endmodule

bind dma_width_adapter dwa_checker #(.AW(AW), .CW(CW)) u_dwa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .p_valid      (p_valid),
    .p_ready      (p_ready),
    .p_addr       (p_addr),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_addr       (m_addr),
    .busy         (busy),
    .done         (done),
    .config_error (config_error),
    .remaining    (remaining),
    .buf_mask     (buf_mask),
    .dst_bytes    (dst_bytes),
    .dst_valid    (dst_valid),
    .p_inc_q      (p_inc_q)
);

// File: tb/tb_dma_width_adapter.sv
module tb_dma_width_adapter;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, dir = 1'b0, p_inc = 1'b0, m_inc = 1'b0, p_fixed4 = 1'b0;
    logic [1:0]    psize = '0, msize = '0;
    logic [CW-1:0] count = '0;
    logic [AW-1:0] p_base = '0, m_base = '0;
    logic          p_valid, p_ready = 1'b0, p_write;
    logic [AW-1:0] p_addr, m_addr;
    logic [31:0]   p_wdata, p_rdata, m_wdata, m_rdata;
    logic          m_valid, m_ready = 1'b0, m_write;
    logic          busy, done, config_error;
    logic [CW-1:0] remaining;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    dma_width_adapter #(.AW(AW), .CW(CW)) dut (.*);

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return a * 32'h9E37_79B1 + 32'h0123_4567;
    endfunction

    assign p_rdata = word_at(p_addr ^ 32'h5500_0000);
    assign m_rdata = word_at(m_addr ^ 32'h00AA_0000);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    int  cur_sb, cur_db, cur_sstep, cur_dstep;
    bit  cur_sinc, cur_dinc;
    logic [31:0] cur_sbase, cur_dbase, cur_sx;

    function automatic logic [7:0] stream_byte(input int k);
        int idx = k / cur_sb;
        int sub = k % cur_sb;
        logic [31:0] a = cur_sbase + (cur_sinc ? 32'(idx * cur_sstep) : 32'd0);
        logic [31:0] w = word_at(a ^ cur_sx);
        return w[8*sub +: 8];
    endfunction

    function automatic logic [31:0] dst_word(input int j);
        logic [31:0] w = '0;
        for (int i = 0; i < cur_db; i++) w[8*i +: 8] = stream_byte(j * cur_db + i);
        return w;
    endfunction

    task automatic run_case(input bit d, input logic [1:0] ps, input logic [1:0] ms,
                            input bit pi, input bit mi, input bit pf, input int ndt,
                            input logic [31:0] pb_a, input logic [31:0] mb_a);
        int pb = 1 << ps, mb = 1 << ms;
        int np = ndt, nm = ndt * pb / mb;
        int pc = 0, mc = 0, cyc = 0;
        int sc, dc;
        bit fin_seen = 0, p_f, m_f;
        int pstep = pf ? 4 : pb;
        logic [31:0] ea;
        cur_sb    = d ? mb : pb;
        cur_db    = d ? pb : mb;
        cur_sstep = d ? mb : pstep;
        cur_dstep = d ? pstep : mb;
        cur_sinc  = d ? mi : pi;
        cur_dinc  = d ? pi : mi;
        cur_sbase = d ? mb_a : pb_a;
        cur_dbase = d ? pb_a : mb_a;
        cur_sx    = d ? 32'h00AA_0000 : 32'h5500_0000;
        dir = d; psize = ps; msize = ms; p_inc = pi; m_inc = mi; p_fixed4 = pf;
        count = CW'(ndt); p_base = pb_a; m_base = mb_a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !config_error && remaining == CW'(ndt), "R10 legal start", {busy, config_error}, 32'h2);
        forever begin
            if (done || fin_seen) begin
                chk(done && fin_seen && remaining == '0 && !busy, "R9 done after last write",
                    {done, fin_seen, busy}, 32'h6);
                chk(pc == np && mc == nm, "R7 transfer counts", {pc[15:0], mc[15:0]},
                    {np[15:0], nm[15:0]});
                break;
            end
            if (cyc > 400) begin
                chk(0, "R9 stream hang", 32'(cyc), 32'd0);
                break;
            end
            p_ready = ($urandom % 4) != 0;
            m_ready = ($urandom % 3) != 0;
            #1;
            p_f = p_valid && p_ready;
            m_f = m_valid && m_ready;
            if (p_f) begin
                chk(p_write == d, "R12 peripheral direction", 32'(p_write), 32'(d));
                chk(remaining == CW'(np - pc), "R7 remaining", 32'(remaining), 32'(np - pc));
                ea = pb_a + (pi ? 32'(pc * pstep) : 32'd0);
                chk(p_addr == ea, pf ? "R4 fixed stride address" : (pi ? "R3 peripheral address" : "R6 held peripheral address"),
                    p_addr, ea);
                if (d) chk(p_wdata == dst_word(pc), pb < mb ? "R2 unpacked data" : "R1 packed data",
                           p_wdata, dst_word(pc));
                pc++;
            end
            if (m_f) begin
                chk(m_write == !d, "R12 memory direction", 32'(m_write), 32'(!d));
                ea = mb_a + (mi ? 32'(mc * mb) : 32'd0);
                chk(m_addr == ea, mi ? "R5 memory address" : "R6 held memory address", m_addr, ea);
                if (!d) chk(m_wdata == dst_word(mc), pb > mb ? "R2 unpacked data" : "R1 packed data",
                            m_wdata, dst_word(mc));
                mc++;
            end
            sc = d ? mc : pc;
            dc = d ? pc : mc;
            if (((d && p_f) || (!d && m_f)) && dc == (d ? np : nm)) fin_seen = 1;
            if (sc > (d ? nm : np)) chk(0, "R11 extra source transfer", 32'(sc), 32'(d ? nm : np));
            @(negedge clk);
            cyc++;
        end
        p_ready = 1'b0; m_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_bad(input logic [1:0] ps, input logic [1:0] ms, input int ndt, input string why);
        bit seen = 0;
        dir = 1'b0; psize = ps; msize = ms; count = CW'(ndt); p_inc = 1; m_inc = 1; p_fixed4 = 0;
        p_ready = 1'b1; m_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(config_error && !busy, {"R10 refused ", why}, {config_error, busy}, 32'h2);
        for (int i = 0; i < 6; i++) begin
            if (p_valid || m_valid || busy) seen = 1;
            @(negedge clk);
        end
        chk(!seen, {"R10 no request ", why}, 32'(seen), 32'd0);
        p_ready = 1'b0; m_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1777));
        repeat (3) @(negedge clk);
        chk(!p_valid && !m_valid && !busy && !done && !config_error && remaining == '0,
            "R9 reset state", {p_valid, m_valid, busy, done, config_error}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++)
            for (int ps = 0; ps < 3; ps++)
                for (int ms = 0; ms < 3; ms++)
                    run_case(d[0], 2'(ps), 2'(ms), 1, 1, (ps + ms) % 2 == 1,
                             8 >> ps, 32'h4000_0000, 32'h2000_0100);
        run_case(0, 2'd0, 2'd2, 1, 1, 1, 4, 32'h0, 32'h0);
        run_case(1, 2'd2, 2'd0, 0, 1, 0, 1, 32'h100, 32'h200);
        run_case(0, 2'd1, 2'd2, 1, 0, 0, 6, 32'h300, 32'h400);
        run_bad(2'd0, 2'd2, 3, "partial word");
        run_bad(2'd1, 2'd2, 1, "half word");
        run_bad(2'd0, 2'd0, 0, "zero count");
        run_bad(2'd3, 2'd0, 4, "size code");
        run_case(0, 2'd0, 2'd0, 1, 1, 0, 2, 32'h10, 32'h20);
        for (int r = 0; r < 40; r++) begin
            int ps = int'($urandom % 3);
            int ms = int'($urandom % 3);
            int mx = (ps > ms) ? ps : ms;
            int n  = ((1 << mx) >> ps) * (1 + int'($urandom % 6));
            run_case(1'($urandom), 2'(ps), 2'(ms), 1'($urandom % 4 != 0), 1'($urandom % 4 != 0),
                     1'($urandom), n, $urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0);
        end
        finish_run();
    end

endmodule